// File: doc/BRIEF.md
# Prioritised Multi-Source Reset Controller

This block takes three asynchronous active-low reset requests (power-on, supply failure and user push-button) and turns them into the internal reset network of a chip. It drives a system reset, a power-on reset and a run indicator. Every reset output asserts at once, with no clock needed, and releases on a clock edge after a two-flop synchroniser.

Alongside the reset network the block holds a small register file with two reset domains. A scratch register and a set of status flags belong to the ordinary domain, which any system reset clears. A memory refresh-period register and a real-time clock value belong to the protected domain, which only power-on reset clears, so they survive supply-fail and user resets. A cold-start flag in the status register records that the last start came from power-on. Software reads this flag after boot and clears it by writing 1 to its bit.

Software reaches all registers through a simple synchronous write port and a combinational read port that share one address.

Top module: `rst_merge_ctrl`

## Requirements
- R1: A low level on any of `pwr_on_rst_ni`, `pwr_fail_ni` or `user_rst_ni` drives `sys_rst_no` low at once, with no clock edge needed.
- R2: After the last active reset input goes high, `sys_rst_no` (and `por_rst_no` for the power-on input) stays low through the first rising clock edge and goes high on the second.
- R3: Power-on reset dominates. While `por_rst_no` is low, `sys_rst_no` and `run_o` are low. After `por_rst_no` releases, `sys_rst_no` stays low as long as another reset input is held low.
- R4: `run_o` is low whenever `sys_rst_no` is low, and rises on the first rising clock edge after both `sys_rst_no` and `por_rst_no` are high.
- R5: Address 0 (scratch, 8 bits) and status bits 7..1 (address 1) read 0 after any system reset.
- R6: Address 2 (refresh period) and address 3 (real-time clock value) keep their values across power-fail and user resets, and read 0 after a power-on reset.
- R7: The cold-start flag is status bit 0. Power-on reset sets it to 1. Power-fail and user resets leave it unchanged. A write to address 1 with bit 0 = 1 clears it, and a write with bit 0 = 0 leaves it unchanged.
- R8: Writes to addresses 2 and 3 are ignored while `sys_rst_no` is low.
- R9: When `wr_en_i` is high, the value on `wdata_i` is stored at `addr_i` on the rising edge. `rdata_o` shows the register at `addr_i` combinationally, and the status register reads as {flags[7:1], cold flag}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| pwr_on_rst_ni | input | 1 | Power-on reset request, active low, asynchronous |
| pwr_fail_ni | input | 1 | Supply-failure reset request, active low, asynchronous |
| user_rst_ni | input | 1 | User reset request, active low, asynchronous |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address for read and write |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 8 | Register read data for `addr_i` |
| sys_rst_no | output | 1 | System reset, active low |
| por_rst_no | output | 1 | Power-on reset, active low |
| run_o | output | 1 | High when the chip is out of every reset |

## Verification
A synchroniser stage stuck or skipped shows up as a release on the wrong edge of `sys_rst_no`, `por_rst_no` or `run_o`. The bench catches that within three clocks of the input release. A wrong reset domain on a register shows on the first read after a power-fail or user reset: a protected register reads 0, or a scratch or flag field keeps stale data. A cold flag or write gate that ignores the reset state gives a wrong status or refresh value on the next read. The register sweep drives every 8-bit value through each address, so a stuck bit or a crossed field shows within one write-read pair.

// File: rtl/rstc_pkg.sv
package rstc_pkg;
  localparam int ADDR_W = 2;
  localparam int NPROT  = 2;
  localparam logic [ADDR_W-1:0] A_SCRATCH = 2'd0;
  localparam logic [ADDR_W-1:0] A_STATUS  = 2'd1;
  localparam logic [ADDR_W-1:0] A_PROT0   = 2'd2; // refresh period, then rtc value
endpackage

// File: rtl/rstc_sync.sv
module rstc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else         q <= {q[STAGES-2:0], 1'b1};
  end

  assign rst_no = q[STAGES-1];
endmodule

// File: rtl/rstc_regs.sv
module rstc_regs
  import rstc_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic                      clk_i,
  input  logic                      sys_rst_ni,
  input  logic                      por_rst_ni,
  input  logic                      wr_en_i,
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic [DW-1:0]             wdata_i,
  output logic [DW-1:0]             rdata_o,
  output logic [DW-1:0]             scratch_o,
  output logic                      cold_o,
  output logic [NPROT-1:0][DW-1:0]  prot_o
);
  logic [DW-1:0] scratch_q;
  logic [DW-1:1] flags_q;
  logic          cold_q;
  logic          wr_ok;

  assign wr_ok = wr_en_i & sys_rst_ni;

  always_ff @(posedge clk_i or negedge sys_rst_ni) begin
    if (!sys_rst_ni) begin
      scratch_q <= '0;
      flags_q   <= '0;
    end else if (wr_en_i) begin
      if (addr_i == A_SCRATCH) scratch_q <= wdata_i;
      if (addr_i == A_STATUS)  flags_q   <= wdata_i[DW-1:1];
    end
  end

  // cold flag lives in the power-on domain, write-1-to-clear
  always_ff @(posedge clk_i or negedge por_rst_ni) begin
    if (!por_rst_ni)                                   cold_q <= 1'b1;
    else if (wr_ok && addr_i == A_STATUS && wdata_i[0]) cold_q <= 1'b0;
  end

  for (genvar g = 0; g < NPROT; g++) begin : g_prot
    logic [DW-1:0] val_q;
    always_ff @(posedge clk_i or negedge por_rst_ni) begin
      if (!por_rst_ni)                                      val_q <= '0;
      else if (wr_ok && addr_i == A_PROT0 + ADDR_W'(g))     val_q <= wdata_i;
    end
    assign prot_o[g] = val_q;
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == A_SCRATCH)     rdata_o = scratch_q;
    else if (addr_i == A_STATUS) rdata_o = {flags_q, cold_q};
    else begin
      for (int k = 0; k < NPROT; k++)
        if (addr_i == A_PROT0 + ADDR_W'(k)) rdata_o = prot_o[k];
    end
  end

  assign scratch_o = scratch_q;
  assign cold_o    = cold_q;
endmodule

// File: rtl/rst_merge_ctrl.sv
module rst_merge_ctrl
  import rstc_pkg::*;
#(
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              pwr_on_rst_ni,
  input  logic              pwr_fail_ni,
  input  logic              user_rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  output logic              sys_rst_no,
  output logic              por_rst_no,
  output logic              run_o
);
  logic                     any_rst_n;
  logic                     sys_rst_n;
  logic                     por_rst_n;
  logic                     run_q;
  logic [DW-1:0]            scratch;
  logic                     cold;
  logic [NPROT-1:0][DW-1:0] prot;

  // power-on is folded into the system chain so it always dominates
  assign any_rst_n = pwr_on_rst_ni & pwr_fail_ni & user_rst_ni;

  rstc_sync #(.STAGES(SYNC_STAGES)) i_por_sync (
    .clk_i  (clk_i),
    .rst_ni (pwr_on_rst_ni),
    .rst_no (por_rst_n)
  );

  rstc_sync #(.STAGES(SYNC_STAGES)) i_sys_sync (
    .clk_i  (clk_i),
    .rst_ni (any_rst_n),
    .rst_no (sys_rst_n)
  );

  always_ff @(posedge clk_i or negedge sys_rst_n) begin
    if (!sys_rst_n) run_q <= 1'b0;
    else            run_q <= por_rst_n;
  end

  rstc_regs #(.DW(DW)) i_regs (
    .clk_i      (clk_i),
    .sys_rst_ni (sys_rst_n),
    .por_rst_ni (por_rst_n),
    .wr_en_i    (wr_en_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .rdata_o    (rdata_o),
    .scratch_o  (scratch),
    .cold_o     (cold),
    .prot_o     (prot)
  );

  assign sys_rst_no = sys_rst_n;
  assign por_rst_no = por_rst_n;
  assign run_o      = run_q;
endmodule

// File: rtl/rstc_chk.sv
module rstc_chk #(
  parameter int DW    = 8,
  parameter int NPROT = 2
) (
  input logic                     clk_i,
  input logic                     pwr_on_rst_ni,
  input logic                     pwr_fail_ni,
  input logic                     user_rst_ni,
  input logic                     sys_rst_no,
  input logic                     por_rst_no,
  input logic                     run_o,
  input logic [DW-1:0]            scratch,
  input logic                     cold,
  input logic [NPROT-1:0][DW-1:0] prot
);
  always @(negedge clk_i) begin
    if (!$isunknown({pwr_on_rst_ni, pwr_fail_ni, user_rst_ni, sys_rst_no,
                     por_rst_no, run_o, scratch, cold})) begin
      AST_ANY_SRC_RESETS: assert (any_low() == 1'b0 || !sys_rst_no); // R1
      AST_POR_DOMINATES: assert (por_rst_no || (!sys_rst_no && !run_o)); // R3
      AST_RUN_NEEDS_RELEASE: assert (!run_o || (sys_rst_no && por_rst_no)); // R4
      AST_ORD_CLEARED: assert (sys_rst_no || scratch == '0); // R5
      AST_COLD_ON_POR: assert (por_rst_no || cold); // R7
    end
  end

  function automatic logic any_low();
    return !pwr_on_rst_ni || !pwr_fail_ni || !user_rst_ni;
  endfunction

  AST_RUN_ONE_LATE: assert property (@(posedge clk_i) disable iff (!sys_rst_no)
    $rose(run_o) |-> $past(sys_rst_no) && $past(por_rst_no)); // R4

  AST_PROT_FROZEN: assert property (@(posedge clk_i) disable iff (!por_rst_no)
    $past(!sys_rst_no) |-> $stable(prot)); // R8

  AST_COLD_KEPT: assert property (@(posedge clk_i) disable iff (!por_rst_no)
    $past(!sys_rst_no) |-> $stable(cold)); // R7
endmodule

bind rst_merge_ctrl rstc_chk #(.DW(DW), .NPROT(rstc_pkg::NPROT)) i_chk (
  .clk_i         (clk_i),
  .pwr_on_rst_ni (pwr_on_rst_ni),
  .pwr_fail_ni   (pwr_fail_ni),
  .user_rst_ni   (user_rst_ni),
  .sys_rst_no    (sys_rst_no),
  .por_rst_no    (por_rst_no),
  .run_o         (run_o),
  .scratch       (scratch),
  .cold          (cold),
  .prot          (prot)
);

// File: tb/test_rst_merge_ctrl.sv
`timescale 1ns/1ps
module test_rst_merge_ctrl;
  logic       clk = 1'b0;
  logic       por_n = 1'b1, pf_n = 1'b1, usr_n = 1'b1;
  logic       we = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wd = 8'd0;
  logic [7:0] rdata;
  logic       sys_n, por_o, run;
  int         checks = 0, fails = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  rst_merge_ctrl i_rst_merge_ctrl (
    .clk_i(clk), .pwr_on_rst_ni(por_n), .pwr_fail_ni(pf_n), .user_rst_ni(usr_n),
    .wr_en_i(we), .addr_i(addr), .wdata_i(wd), .rdata_o(rdata),
    .sys_rst_no(sys_n), .por_rst_no(por_o), .run_o(run)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    we = 1'b1; addr = a; wd = d;
    tick();
    we = 1'b0;
  endtask

  task automatic rd(input string tag, input logic [1:0] a, input logic [7:0] exp);
    addr = a; #1;
    chk(tag, rdata, exp);
  endtask

  // apply power-fail (sel=0) or user (sel=1) reset with a write attempt inside it
  task automatic soft_reset(input bit sel, input logic [7:0] cold_exp);
    wr(2'd0, 8'h77); wr(2'd1, {7'h55, 1'b0});
    if (sel) usr_n = 1'b0; else pf_n = 1'b0;
    #1;
    chk("R1 sys low without clock", sys_n, 1'b0);
    chk("R3 por unaffected by soft reset", por_o, 1'b1);
    chk("R4 run low in reset", run, 1'b0);
    wr(2'd2, 8'h11);
    wr(2'd3, 8'h22);
    if (sel) usr_n = 1'b1; else pf_n = 1'b1;
    tick(); chk("R2 sys held after first edge", sys_n, 1'b0);
    tick(); chk("R2 sys released on second edge", sys_n, 1'b1);
    chk("R4 run one edge late", run, 1'b0);
    tick(); chk("R4 run high", run, 1'b1);
    rd("R5 scratch cleared", 2'd0, 8'h00);
    rd("R5 R7 flags cleared cold kept", 2'd1, cold_exp);
    rd("R6 R8 refresh kept", 2'd2, 8'h5A);
    rd("R6 R8 rtc kept", 2'd3, 8'hC3);
  endtask

  initial begin
    por_n = 1'b0;
    tick(); tick();
    chk("R3 sys low in por", sys_n, 1'b0);
    chk("R3 por out low", por_o, 1'b0);
    chk("R3 run low in por", run, 1'b0);
    por_n = 1'b1; #1;
    chk("R2 no release before edge", por_o, 1'b0);
    tick(); chk("R2 por held after first edge", por_o, 1'b0);
    tick(); chk("R2 por released", por_o, 1'b1);
    chk("R2 sys released", sys_n, 1'b1);
    chk("R4 run still low", run, 1'b0);
    tick(); chk("R4 run rises", run, 1'b1);
    rd("R7 cold set by por", 2'd1, 8'h01);
    rd("R5 scratch zero", 2'd0, 8'h00);
    rd("R6 refresh zero", 2'd2, 8'h00);
    rd("R6 rtc zero", 2'd3, 8'h00);
    wr(2'd1, 8'h00); rd("R7 write 0 keeps cold", 2'd1, 8'h01);
    wr(2'd1, 8'hA0); rd("R9 flags written", 2'd1, 8'hA1);

    wr(2'd2, 8'h5A); wr(2'd3, 8'hC3);
    soft_reset(1'b0, 8'h01);
    wr(2'd1, 8'h01); rd("R7 write 1 clears cold", 2'd1, 8'h00);
    soft_reset(1'b1, 8'h00);

    for (int v = 0; v < 256; v++) begin
      logic [7:0] b;
      b = 8'(v);
      wr(2'd0, b); wr(2'd2, b ^ 8'hFF); wr(2'd3, b + 8'd1); wr(2'd1, b);
      rd("R9 scratch sweep", 2'd0, b);
      rd("R9 refresh sweep", 2'd2, b ^ 8'hFF);
      rd("R9 rtc sweep", 2'd3, b + 8'd1);
      rd("R9 R7 status sweep", 2'd1, {b[7:1], 1'b0});
    end

    usr_n = 1'b0; por_n = 1'b0; #1;
    chk("R1 por asserts sys async", sys_n, 1'b0);
    chk("R3 por out async", por_o, 1'b0);
    chk("R3 run low", run, 1'b0);
    tick(); tick();
    por_n = 1'b1;
    tick(); tick();
    chk("R2 por released with user held", por_o, 1'b1);
    chk("R3 sys held by user reset", sys_n, 1'b0);
    chk("R4 run low while sys low", run, 1'b0);
    rd("R6 refresh cleared by por", 2'd2, 8'h00);
    rd("R6 rtc cleared by por", 2'd3, 8'h00);
    rd("R7 cold set again", 2'd1, 8'h01);
    wr(2'd2, 8'h99);
    usr_n = 1'b1;
    tick(); tick(); tick();
    chk("R4 run after user release", run, 1'b1);
    rd("R8 write in reset ignored", 2'd2, 8'h00);
    wr(2'd3, 8'h3C); rd("R9 rtc write after reset", 2'd3, 8'h3C);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL R2 watchdog act=hung exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule